// File: doc/BRIEF.md
# Radix-4 Digit-Reversal Reorder Buffer

A radix-4 decimation-in-frequency transform delivers its results with the base-4 digits of the frequency index in reverse order. This block sits on that stream and hands the samples on in natural frequency order. It holds two frame-sized storage banks. The producer fills one bank in arrival order while the consumer drains the other. The read address is the base-4 digit reversal of a plain natural-order counter. When the write side completes a frame and the read side is free, the two banks swap roles, so a steady stream of equal-size frames passes through without a pause.

The frame length is chosen per frame from three sizes: 256, 1024 and 2048 points by default. The size is taken with the frame-start sample. The 2048-point size has one binary digit left over after the base-4 digits, and that digit is handled as a single trailing bit. A frame start that arrives before the current frame is complete is reported on an error pulse. It also discards the partial frame.

Both streams use valid/ready handshakes. A sample moves when valid and ready are both high at a rising clock edge. The output holds `out_valid` and `out_data` until it is taken. `in_ready` falls only when a completed frame is waiting for the read bank and the consumer has not yet drained the previous frame. With `out_ready` held high and equal-size frames, `in_ready` never falls.

Top module: `r4_digit_reorder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `frame_err` is 0.
- R2: `size_sel` is sampled with the accepted `in_sof` sample and fixes that frame's length: 0 selects 256, 1 selects 1024, and 2 or 3 select 2048. A change of `size_sel` inside a frame has no effect until the next frame start.
- R3: For 256 and 1024 points, output sample k of a frame is the input sample whose 0-based arrival position within the frame equals k with the order of its base-4 digits reversed.
- R4: For 2048 points, output sample k is the input at position {digit-reversal of k[9:0], k[10]}: the reversed base-4 digits of the low ten bits fill position bits 10..1, and the top bit of k becomes position bit 0.
- R5: An accepted input sample without `in_sof` while no frame is open is discarded and never appears at the output.
- R6: When the read side is idle, the first output sample of a frame is valid in the cycle after the frame's last input sample is accepted.
- R7: With `out_ready` held high and back-to-back frames of equal size, `in_ready` stays 1 and `out_valid` stays 1 from the first output sample until the final frame is drained.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. `in_ready` is 0 only while a completed frame waits for the read bank. No sample is lost or duplicated.
- R9: Accepting `in_sof` while a frame is partly written drives `frame_err` high for exactly the next cycle. The partial frame is discarded and the new frame starts at position 0.
- R10: `out_sof` is 1 with the first output sample of each frame and 0 with every other sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept an input sample |
| in_sof | input | 1 | Input sample is position 0 of a new frame |
| in_data | input | DATA_W | Input sample, digit-reversed order |
| size_sel | input | 2 | Frame length select, sampled with `in_sof` |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample |
| out_sof | output | 1 | Output sample is the first of its frame |
| out_data | output | DATA_W | Output sample, natural order |
| frame_err | output | 1 | One-cycle pulse: frame start cut a frame short |

## Verification
The hardest state to reach is a completed frame waiting for a bank while the consumer still holds unread samples. In that state `in_ready` must drop and no sample may be lost. The bench reaches it in two ways: a long frame followed at once by short ones, and a long pattern of `out_ready` gaps while full-rate input continues. A behavioural queue model then confirms that every sample comes out once and in order. A second hard case is a frame start inside an open frame. The bench forces it after a partial frame and checks that the error pulse appears and that only the new frame comes out.

// File: rtl/r4_reorder_pkg.sv
package r4_reorder_pkg;

  typedef enum logic [1:0] {
    FRM_SMALL = 2'd0,
    FRM_MID   = 2'd1,
    FRM_LARGE = 2'd2,
    FRM_LARGE2 = 2'd3
  } frm_sel_e;

  // Maps a size code to the log2 of the frame length.
  function automatic int unsigned pick_log2(frm_sel_e s, int unsigned lg_s,
                                            int unsigned lg_m, int unsigned lg_l);
    case (s)
      FRM_SMALL: return lg_s;
      FRM_MID:   return lg_m;
      default:   return lg_l;
    endcase
  endfunction

endpackage

// File: rtl/r4_rev.sv
// Address permutation for one frame size: base-4 digit reversal, with a
// single trailing binary digit moved to bit 0 when the exponent is odd.
module r4_rev #(
  parameter int unsigned LOG2N = 8
) (
  input  logic [LOG2N-1:0] idx,
  output logic [LOG2N-1:0] addr
);
  localparam int unsigned ODD = LOG2N % 2;
  localparam int unsigned ND  = LOG2N / 2;

  for (genvar d = 0; d < ND; d++) begin : g_digit
    assign addr[2*d+ODD +: 2] = idx[2*(ND-1-d) +: 2];
  end

  if (ODD == 1) begin : g_odd
    assign addr[0] = idx[LOG2N-1];
  end
endmodule

// File: rtl/r4_wr_ctrl.sv
module r4_wr_ctrl
  import r4_reorder_pkg::*;
#(
  parameter int unsigned AW     = 11,
  parameter int unsigned LW     = 4,
  parameter int unsigned LOG2_S = 8,
  parameter int unsigned LOG2_M = 10,
  parameter int unsigned LOG2_L = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [1:0]    size_sel,
  input  logic          swap_ok,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_bank,
  output logic          handoff,
  output logic [LW-1:0] handoff_log2,
  output logic          frame_err
);
  logic          open_q, full_q, bank_q;
  logic [AW-1:0] cnt_q;
  logic [LW-1:0] log2_q, sel_log2, eff_log2;
  logic [AW:0]   lim;
  logic          fire, accept, last;

  assign sel_log2 = LW'(pick_log2(frm_sel_e'(size_sel), LOG2_S, LOG2_M, LOG2_L));
  assign in_ready = !full_q;
  assign fire     = in_valid && in_ready;
  assign accept   = fire && (in_sof || open_q);
  assign eff_log2 = (fire && in_sof) ? sel_log2 : log2_q;
  assign wr_addr  = in_sof ? '0 : cnt_q;
  assign lim      = (AW+1)'(1) << eff_log2;
  assign last     = accept && ({1'b0, wr_addr} == lim - 1'b1);
  assign handoff  = (last || full_q) && swap_ok;
  assign handoff_log2 = eff_log2;
  assign wr_en    = accept;
  assign wr_bank  = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      full_q    <= 1'b0;
      bank_q    <= 1'b0;
      cnt_q     <= '0;
      log2_q    <= LW'(LOG2_S);
      frame_err <= 1'b0;
    end else begin
      frame_err <= fire && in_sof && open_q;
      if (accept) begin
        if (in_sof) log2_q <= sel_log2;
        if (last) begin
          open_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          open_q <= 1'b1;
          cnt_q  <= wr_addr + 1'b1;
        end
      end
      if (handoff) begin
        full_q <= 1'b0;
        bank_q <= ~bank_q;
      end else if (last) begin
        full_q <= 1'b1;
      end
    end
  end

  // A pulse on the error output always follows an accepted frame start.
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(in_valid && in_ready && in_sof));
endmodule

// File: rtl/r4_rd_ctrl.sv
module r4_rd_ctrl #(
  parameter int unsigned AW = 11,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] start_log2,
  input  logic          start_bank,
  input  logic          out_ready,
  output logic          busy,
  output logic          rd_bank,
  output logic [AW-1:0] rd_cnt,
  output logic [LW-1:0] rd_log2,
  output logic          rd_last,
  output logic          out_sof
);
  logic [AW:0] lim;
  logic        fire;

  assign lim     = (AW+1)'(1) << rd_log2;
  assign fire    = busy && out_ready;
  assign rd_last = fire && ({1'b0, rd_cnt} == lim - 1'b1);
  assign out_sof = busy && (rd_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_bank <= 1'b1;
      rd_cnt  <= '0;
      rd_log2 <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      rd_bank <= start_bank;
      rd_cnt  <= '0;
      rd_log2 <= start_log2;
    end else if (rd_last) begin
      busy   <= 1'b0;
      rd_cnt <= '0;
    end else if (fire) begin
      rd_cnt <= rd_cnt + 1'b1;
    end
  end

  // After the first sample of a frame is taken, the marker is not repeated.
  p_sof_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && out_ready && !start) |=> !out_sof);
endmodule

// File: rtl/r4_pp_store.sv
module r4_pp_store #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic          w_bank,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data,
  input  logic          r_bank,
  input  logic [AW-1:0] r_addr,
  output logic [DW-1:0] r_data
);
  localparam int unsigned DEPTH = 2 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{w_bank, w_addr}] <= w_data;
  end

  assign r_data = mem[{r_bank, r_addr}];
endmodule

// File: rtl/r4_digit_reorder.sv
module r4_digit_reorder #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LOG2_SMALL = 8,
  parameter int unsigned LOG2_MID   = 10,
  parameter int unsigned LOG2_LARGE = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        size_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sof,
  output logic [DATA_W-1:0] out_data,
  output logic              frame_err
);
  localparam int unsigned AW     = LOG2_LARGE;
  localparam int unsigned LW     = $clog2(AW + 1);
  localparam int unsigned NSIZES = 3;

  function automatic int unsigned size_log2(int unsigned g);
    return (g == 0) ? LOG2_SMALL : (g == 1) ? LOG2_MID : LOG2_LARGE;
  endfunction

  logic          wr_en, wr_bank, handoff, swap_ok;
  logic [AW-1:0] wr_addr, rd_cnt, rd_addr;
  logic [LW-1:0] handoff_log2, rd_log2;
  logic          rd_busy, rd_bank, rd_last;
  logic [AW-1:0] rev_cand [NSIZES];

  assign swap_ok = !rd_busy || rd_last;

  r4_wr_ctrl #(
    .AW(AW), .LW(LW), .LOG2_S(LOG2_SMALL), .LOG2_M(LOG2_MID), .LOG2_L(LOG2_LARGE)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .size_sel(size_sel), .swap_ok(swap_ok), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bank(wr_bank), .handoff(handoff),
    .handoff_log2(handoff_log2), .frame_err(frame_err)
  );

  r4_rd_ctrl #(.AW(AW), .LW(LW)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(handoff), .start_log2(handoff_log2),
    .start_bank(wr_bank), .out_ready(out_ready), .busy(rd_busy),
    .rd_bank(rd_bank), .rd_cnt(rd_cnt), .rd_log2(rd_log2),
    .rd_last(rd_last), .out_sof(out_sof)
  );

  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    localparam int unsigned LG = size_log2(g);
    logic [LG-1:0] perm;
    r4_rev #(.LOG2N(LG)) u_rev (.idx(rd_cnt[LG-1:0]), .addr(perm));
    assign rev_cand[g] = AW'(perm);
  end

  always_comb begin
    rd_addr = '0;
    for (int g = 0; g < NSIZES; g++) begin
      if (rd_log2 == LW'(size_log2(g))) rd_addr = rev_cand[g];
    end
  end

  r4_pp_store #(.DW(DATA_W), .AW(AW)) u_store (
    .clk(clk), .we(wr_en), .w_bank(wr_bank), .w_addr(wr_addr), .w_data(in_data),
    .r_bank(rd_bank), .r_addr(rd_addr), .r_data(out_data)
  );

  assign out_valid = rd_busy;

  // Writer never touches the bank being drained.
  p_bank_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_busy) |-> (wr_bank != rd_bank));
  // A stalled output sample holds still.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // Input back-pressure only while the read side is still occupied.
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> rd_busy);
  // Error pulse needs the write side to have been mid-frame.
  p_err_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(!wr_en || wr_addr == '0));
endmodule

// File: tb/test_r4_digit_reorder.sv
module test_r4_digit_reorder;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic [1:0] size_sel = 2'd0;
  logic in_ready, out_valid, out_sof, frame_err;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;

  r4_digit_reorder i_r4_digit_reorder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .size_sel(size_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
    .out_data(out_data), .frame_err(frame_err)
  );

  int checks = 0, errors = 0, cyc = 0;
  int exp_d[$], exp_s[$], exp_lg[$];
  int buff[$];
  bit mdl_open = 0, err_due = 0, mon_on = 0, cont_on = 0, bp_mode = 0;
  int mdl_lg = 8, n_out = 0, saw_stall = 0, last_in_cyc = -1, first_out_cyc = -1;
  logic prev_stall = 0;
  logic [DW-1:0] prev_data = '0;

  function automatic int lg_of(int s);
    return (s == 0) ? 8 : (s == 1) ? 10 : 11;
  endfunction

  function automatic int rev4(int k, int lg);
    int top = 0, body = k, r = 0;
    if (lg % 2 == 1) begin
      top = (k >> (lg - 1)) & 1;
      body = k & ((1 << (lg - 1)) - 1);
    end
    for (int d = 0; d < lg / 2; d++) r = (r << 2) | ((body >> (2 * d)) & 3);
    return (lg % 2 == 1) ? ((r << 1) | top) : r;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor and reference model, sampled on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (mon_on) begin
      check(frame_err == err_due, "R9 error pulse", frame_err, err_due);
      if (cont_on) begin
        check(in_ready, "R7 in_ready", in_ready, 1);
        if (exp_d.size() > 0) check(out_valid, "R7 gapless", out_valid, 1);
      end
      if (bp_mode && prev_stall)
        check(out_valid && out_data == prev_data, "R8 hold", out_data, prev_data);
      if (!in_ready) saw_stall++;
      if (out_valid && first_out_cyc < 0) first_out_cyc = cyc;
      if (out_valid && exp_d.size() == 0) check(0, "R8 spurious output", 1, 0);
      if (out_valid && out_ready && exp_d.size() > 0) begin
        check(out_data == exp_d[0], (exp_lg[0] % 2 == 1) ? "R4 data" : "R3 data",
              out_data, exp_d[0]);
        check(out_sof == exp_s[0], "R10 out_sof", out_sof, exp_s[0]);
        void'(exp_d.pop_front()); void'(exp_s.pop_front()); void'(exp_lg.pop_front());
        n_out++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      err_due = in_valid && in_ready && in_sof && mdl_open;
      if (in_valid && in_ready && (in_sof || mdl_open)) begin
        if (in_sof) begin
          buff = {};
          mdl_lg = lg_of(size_sel);
        end
        buff.push_back(in_data);
        mdl_open = 1;
        if (buff.size() == (1 << mdl_lg)) begin
          for (int k = 0; k < (1 << mdl_lg); k++) begin
            exp_d.push_back(buff[rev4(k, mdl_lg)]);
            exp_s.push_back(k == 0);
            exp_lg.push_back(mdl_lg);
          end
          mdl_open = 0;
          last_in_cyc = cyc;
        end
      end
    end
  end

  initial begin : ready_drv
    forever begin
      @(posedge clk); #1;
      if (bp_mode) out_ready = ((cyc % 7) != 0) && ((cyc % 29) < 20);
      else out_ready = 1'b1;
    end
  end

  task automatic push(bit sof, int data, int sel);
    bit ok;
    in_valid = 1'b1; in_sof = sof; in_data = DW'(data); size_sel = 2'(sel);
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_frame(int sel, int tag, int gap);
    for (int i = 0; i < (1 << lg_of(sel)); i++) begin
      push(i == 0, (tag << 11) | i, sel);
      if (gap > 0 && i % gap == 3) begin @(posedge clk); #1; end
    end
  endtask

  task automatic drain(string req);
    int t = 0;
    while ((exp_d.size() > 0 || out_valid) && t < 6000) begin
      @(posedge clk); #1; t++;
    end
    check(exp_d.size() == 0 && !out_valid, req, exp_d.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1, "R1 in_ready", in_ready, 1);
    check(frame_err == 0, "R1 frame_err", frame_err, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1;
    @(posedge clk); #1;

    // R6 latency and R3 order on a 256 frame
    first_out_cyc = -1;
    send_frame(0, 1, 0);
    drain("R3 drain 256");
    check(first_out_cyc == last_in_cyc + 1, "R6 latency", first_out_cyc, last_in_cyc + 1);

    // R5 stray samples then a 1024 frame with input gaps
    for (int i = 0; i < 5; i++) push(0, 16'hBEEF, 1);
    n_out = 0;
    send_frame(1, 2, 9);
    drain("R5 drain");
    check(n_out == 1024, "R5 output count", n_out, 1024);

    // R4 both large codes
    send_frame(2, 3, 0);
    send_frame(3, 4, 0);
    drain("R4 drain 2048");

    // R7 back-to-back equal frames
    cont_on = 1;
    for (int f = 0; f < 3; f++) send_frame(0, 5 + f, 0);
    drain("R7 drain");
    cont_on = 0;

    // R2 size change inside a frame is ignored
    n_out = 0;
    for (int i = 0; i < 256; i++) push(i == 0, (8 << 11) | i, (i == 0) ? 0 : 1);
    drain("R2 captured size");
    check(n_out == 256, "R2 frame length", n_out, 256);
    n_out = 0;
    send_frame(1, 9, 0);
    drain("R2 next size");
    check(n_out == 1024, "R2 new length", n_out, 1024);

    // R9 early frame start
    n_out = 0;
    for (int i = 0; i < 100; i++) push(i == 0, (10 << 11) | i, 0);
    send_frame(1, 11, 0);
    drain("R9 drain");
    check(n_out == 1024, "R9 partial discarded", n_out, 1024);

    // R8 back-pressure and long-then-short frames
    saw_stall = 0;
    bp_mode = 1;
    send_frame(1, 12, 0);
    for (int f = 0; f < 3; f++) send_frame(0, 13 + f, 0);
    send_frame(2, 16, 0);
    drain("R8 drain");
    bp_mode = 0;
    check(saw_stall > 0, "R8 stall reached", saw_stall, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule